// File: doc/BRIEF.md
# Two-Phase Multiprefix Add Unit

This block sits beside a multithreaded processor and carries out concurrent multiprefix additions in two consecutive steps. In the begin step every participating thread presents an address and a contribution. Threads that hit the same address are combined in a small step cache. The first thread to claim a line becomes the initiator. Each thread receives the running sum of the contributions accepted before its own, and the initiator's scratchpad entry holds the running total. A step boundary pulse empties the cache, so its contents never outlive one step.

In the end step only the initiator sends a single fetch-and-add request to an attached memory bank. The bank returns the old word and stores the old word plus the total. Every other thread obtains its result from the initiator's scratchpad. If the reply is still outstanding, that thread is parked and released once the reply arrives. Operations are issued one per cycle, in thread order, so the accumulation order is fixed.

The control is a three-state machine. ST_IDLE accepts operations. On an initiator request it moves to ST_WAIT, which keeps accepting operations until the reply cycle. The reply leads to ST_DRAIN if any thread is parked, and to ST_IDLE otherwise. ST_DRAIN releases one parked thread per cycle, lowest thread first, and returns to ST_IDLE after the last one.

Top module: `mpa_unit`

## Requirements
- R1: After reset, res_valid, retry and addr_err are 0, op_ready is 1, every memory word is 0 and the cache holds no line.
- R2: A begin operation (op_end=0) that misses on a free line returns result 0 one cycle later. The line then holds the address and data, with this thread as initiator, and the thread's scratchpad entry holds the same address and data.
- R3: A begin operation that hits returns the line's current sum. The line and the initiator's scratchpad data both become that sum plus the operation's data, and the thread records the line's initiator.
- R4: A begin operation whose line index (address modulo LINES) holds a different address asserts retry for one cycle, produces no result and leaves the line unchanged.
- R5: A one-cycle step_end pulse empties every cache line, so the next begin operation on any address misses.
- R6: An end operation (op_end=1) by a non-initiator whose initiator is not pending returns its data plus the initiator's scratchpad data, one cycle later.
- R7: An initiator end operation whose address equals its scratchpad address sends one fetch-and-add request carrying the scratchpad total and marks the entry pending. The initiator's result, the old memory word, appears three edges after issue. The memory word becomes old plus total.
- R8: A non-initiator end operation issued while its initiator is pending gives no immediate result. After the initiator's reply, ST_DRAIN releases it with the reply value plus its own data, lowest thread first, one per cycle.
- R9: An initiator end operation whose address differs from its scratchpad address asserts addr_err for one cycle and sends no request.
- R10: An initiator end operation that arrives while a request is outstanding asserts retry and sends nothing. At most one request is outstanding.
- R11: In any cycle at most one of res_valid, retry and addr_err is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_end | input | 1 | Step boundary pulse; empties the cache |
| op_valid | input | 1 | Operation presented this cycle |
| op_end | input | 1 | 0 = begin step, 1 = end step |
| op_thread | input | $clog2(THREADS) | Issuing thread |
| op_addr | input | ADDR_W | Target word address |
| op_data | input | DATA_W | Contribution or end-step data |
| op_ready | output | 1 | Operation is accepted this cycle |
| res_valid | output | 1 | Result for res_thread |
| res_thread | output | $clog2(THREADS) | Thread of the outcome |
| res_data | output | DATA_W | Result value |
| retry | output | 1 | Operation refused; reissue it |
| addr_err | output | 1 | Initiator address mismatch |

## Verification
A wrong running sum in a cache line shows up on the very next hitting begin operation, one cycle after issue. A wrong scratchpad total shows up only at the end step, as a wrong immediate result for a non-initiator or as a wrong old word returned by the next round on that address. A stuck pending bit or a lost parked thread shows up as a result that never arrives, or as retry on a later initiator. Each scenario therefore follows its address through a second round, and tracks thread identity as well as value on every result.

// File: rtl/mpa_pkg.sv
package mpa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DRAIN = 2'd2
    } mpa_state_e;
endpackage

// File: rtl/mpa_step_cache.sv
module mpa_step_cache #(
    parameter int LINES  = 2,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int TID_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              hit,
    output logic              conflict,
    output logic [DATA_W-1:0] rd_data,
    output logic [TID_W-1:0]  rd_init,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TID_W-1:0]  wr_init,
    output logic [LINES-1:0]  used_q
);
    localparam int IDX_W = $clog2(LINES);

    logic [ADDR_W-1:0] tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];
    logic [TID_W-1:0]  init_q [LINES];
    logic [IDX_W-1:0]  lk_idx, wr_idx;

    assign lk_idx   = lk_addr[IDX_W-1:0];
    assign wr_idx   = wr_addr[IDX_W-1:0];
    assign hit      = used_q[lk_idx] && (tag_q[lk_idx] == lk_addr);
    assign conflict = used_q[lk_idx] && (tag_q[lk_idx] != lk_addr);
    assign rd_data  = data_q[lk_idx];
    assign rd_init  = init_q[lk_idx];

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            used_q <= '0;
        end else if (wr_en) begin
            used_q[wr_idx] <= 1'b1;
            tag_q[wr_idx]  <= wr_addr;
            data_q[wr_idx] <= wr_data;
            init_q[wr_idx] <= wr_init;
        end
    end
endmodule

// File: rtl/mpa_mem_bank.sv
module mpa_mem_bank #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int TID_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [TID_W-1:0]  req_tid,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [TID_W-1:0]  rsp_tid
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_tid   <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_data        <= mem_q[req_addr];
                rsp_tid         <= req_tid;
                mem_q[req_addr] <= mem_q[req_addr] + req_data;
            end
        end
    end
endmodule

// File: rtl/mpa_unit.sv
module mpa_unit
    import mpa_pkg::*;
#(
    parameter int THREADS = 4,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 4,
    parameter int LINES   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       step_end,
    input  logic                       op_valid,
    input  logic                       op_end,
    input  logic [$clog2(THREADS)-1:0] op_thread,
    input  logic [ADDR_W-1:0]          op_addr,
    input  logic [DATA_W-1:0]          op_data,
    output logic                       op_ready,
    output logic                       res_valid,
    output logic [$clog2(THREADS)-1:0] res_thread,
    output logic [DATA_W-1:0]          res_data,
    output logic                       retry,
    output logic                       addr_err
);
    localparam int TID_W = $clog2(THREADS);

    mpa_state_e state_q, state_d;

    logic [DATA_W-1:0] sp_data [THREADS];
    logic [ADDR_W-1:0] sp_addr [THREADS];
    logic [THREADS-1:0] sp_pend;
    logic [TID_W-1:0]  init_of [THREADS];
    logic [THREADS-1:0] wait_q;
    logic [DATA_W-1:0] wt_data [THREADS];
    logic [TID_W-1:0]  cur_init;

    logic              mreq_valid;
    logic [ADDR_W-1:0] mreq_addr;
    logic [DATA_W-1:0] mreq_data;
    logic [TID_W-1:0]  mreq_tid;
    logic              b_rvalid;
    logic [DATA_W-1:0] b_rdata;
    logic [TID_W-1:0]  b_rtid;

    logic              c_hit, c_conf, c_wr;
    logic [DATA_W-1:0] c_rdata, c_wdata;
    logic [TID_W-1:0]  c_init, c_winit;
    logic [LINES-1:0]  c_used;

    logic acc, is_init, rsp;
    logic b_hit, b_miss, b_conf, e_wait, e_now, e_bad, e_busy, e_send;
    logic [TID_W-1:0]   me_init, pick;
    logic [THREADS-1:0] rest;

    mpa_step_cache #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TID_W(TID_W)) u_cache (
        .clk(clk), .rst_n(rst_n), .clear(step_end),
        .lk_addr(op_addr), .hit(c_hit), .conflict(c_conf),
        .rd_data(c_rdata), .rd_init(c_init),
        .wr_en(c_wr), .wr_addr(op_addr), .wr_data(c_wdata), .wr_init(c_winit),
        .used_q(c_used)
    );

    mpa_mem_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TID_W(TID_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .req_valid(mreq_valid), .req_addr(mreq_addr), .req_data(mreq_data), .req_tid(mreq_tid),
        .rsp_valid(b_rvalid), .rsp_data(b_rdata), .rsp_tid(b_rtid)
    );

    // operation decode
    assign op_ready = (state_q == ST_IDLE) || (state_q == ST_WAIT && !b_rvalid);
    assign acc      = op_valid && op_ready;
    assign me_init  = init_of[op_thread];
    assign is_init  = (me_init == op_thread);
    assign rsp      = (state_q == ST_WAIT) && b_rvalid;

    assign b_hit  = acc && !op_end && c_hit;
    assign b_conf = acc && !op_end && c_conf;
    assign b_miss = acc && !op_end && !c_hit && !c_conf;
    assign e_wait = acc && op_end && !is_init && sp_pend[me_init];
    assign e_now  = acc && op_end && !is_init && !sp_pend[me_init];
    assign e_bad  = acc && op_end && is_init && (op_addr != sp_addr[me_init]);
    assign e_busy = acc && op_end && is_init && !e_bad && (state_q == ST_WAIT);
    assign e_send = acc && op_end && is_init && !e_bad && (state_q == ST_IDLE);

    assign c_wr    = b_hit || b_miss;
    assign c_wdata = b_hit ? (c_rdata + op_data) : op_data;
    assign c_winit = b_hit ? c_init : op_thread;

    // lowest parked thread
    always_comb begin
        pick = '0;
        for (int i = THREADS - 1; i >= 0; i--) begin
            if (wait_q[i]) pick = TID_W'(i);
        end
        rest = wait_q & ~(THREADS'(1) << pick);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (e_send) state_d = ST_WAIT;
            ST_WAIT:  if (rsp) state_d = (|wait_q) ? ST_DRAIN : ST_IDLE;
            ST_DRAIN: if (rest == '0) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and per-thread state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_thread <= '0;
            res_data   <= '0;
            retry      <= 1'b0;
            addr_err   <= 1'b0;
            mreq_valid <= 1'b0;
            mreq_addr  <= '0;
            mreq_data  <= '0;
            mreq_tid   <= '0;
            sp_pend    <= '0;
            wait_q     <= '0;
            cur_init   <= '0;
            for (int i = 0; i < THREADS; i++) begin
                sp_data[i] <= '0;
                sp_addr[i] <= '0;
                init_of[i] <= TID_W'(i);
                wt_data[i] <= '0;
            end
        end else begin
            res_valid  <= 1'b0;
            retry      <= b_conf || e_busy;
            addr_err   <= e_bad;
            mreq_valid <= 1'b0;
            if (acc) res_thread <= op_thread;
            if (b_hit) begin
                res_valid          <= 1'b1;
                res_data           <= c_rdata;
                sp_data[c_init]    <= c_rdata + op_data;
                init_of[op_thread] <= c_init;
            end
            if (b_miss) begin
                res_valid          <= 1'b1;
                res_data           <= '0;
                sp_data[op_thread] <= op_data;
                sp_addr[op_thread] <= op_addr;
                init_of[op_thread] <= op_thread;
            end
            if (e_wait) begin
                wait_q[op_thread]  <= 1'b1;
                wt_data[op_thread] <= op_data;
            end
            if (e_now) begin
                res_valid <= 1'b1;
                res_data  <= op_data + sp_data[me_init];
            end
            if (e_send) begin
                mreq_valid         <= 1'b1;
                mreq_addr          <= op_addr;
                mreq_data          <= sp_data[me_init];
                mreq_tid           <= op_thread;
                sp_pend[op_thread] <= 1'b1;
                cur_init           <= op_thread;
            end
            if (rsp) begin
                res_valid       <= 1'b1;
                res_thread      <= b_rtid;
                res_data        <= b_rdata;
                sp_data[b_rtid] <= b_rdata;
                sp_pend[b_rtid] <= 1'b0;
            end
            if (state_q == ST_DRAIN) begin
                res_valid    <= 1'b1;
                res_thread   <= pick;
                res_data     <= wt_data[pick] + sp_data[cur_init];
                wait_q[pick] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mpa_unit_chk.sv
module mpa_unit_chk #(
    parameter int THREADS = 4,
    parameter int LINES   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               step_end,
    input logic               res_valid,
    input logic               retry,
    input logic               addr_err,
    input logic               mreq_valid,
    input logic               rsp_valid,
    input logic [THREADS-1:0] sp_pend,
    input logic [THREADS-1:0] wait_q,
    input logic               in_drain,
    input logic [LINES-1:0]   lines_used
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_valid, retry, addr_err})); // R11
    AST_REQ_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid |=> !mreq_valid); // R10
    AST_ONE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sp_pend)); // R10
    AST_REPLY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(mreq_valid)); // R7
    AST_DRAIN_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        in_drain |-> (wait_q != '0)); // R8
    AST_STEP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(step_end) |-> (lines_used == '0)); // R5
endmodule

bind mpa_unit mpa_unit_chk #(.THREADS(THREADS), .LINES(LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .step_end(step_end),
    .res_valid(res_valid), .retry(retry), .addr_err(addr_err),
    .mreq_valid(mreq_valid), .rsp_valid(b_rvalid),
    .sp_pend(sp_pend), .wait_q(wait_q),
    .in_drain(state_q == mpa_pkg::ST_DRAIN),
    .lines_used(c_used)
);

// File: tb/mpa_unit_test.sv
module mpa_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_end = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_end = 1'b0;
    logic [1:0]  op_thread = '0;
    logic [3:0]  op_addr = '0;
    logic [15:0] op_data = '0;
    logic        op_ready, res_valid, retry, addr_err;
    logic [1:0]  res_thread;
    logic [15:0] res_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    mpa_unit uut (
        .clk(clk), .rst_n(rst_n), .step_end(step_end),
        .op_valid(op_valid), .op_end(op_end), .op_thread(op_thread),
        .op_addr(op_addr), .op_data(op_data), .op_ready(op_ready),
        .res_valid(res_valid), .res_thread(res_thread), .res_data(res_data),
        .retry(retry), .addr_err(addr_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive one operation; returns at the negedge after it is taken
    task automatic issue(input logic e, input int thr, input int a, input int d);
        int guard = 0;
        while (!op_ready && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        op_valid  = 1'b1;
        op_end    = e;
        op_thread = 2'(thr);
        op_addr   = 4'(a);
        op_data   = 16'(d);
        @(negedge clk);
        op_valid  = 1'b0;
    endtask

    task automatic expect_res(input string req, input int thr, input int d);
        check({req, " valid"}, {31'd0, res_valid}, 1);
        check({req, " thread"}, {30'd0, res_thread}, 32'(thr));
        check({req, " data"}, {16'd0, res_data}, 32'(d));
    endtask

    task automatic wait_res(input string req, input int thr, input int d);
        bit found = 1'b0;
        for (int i = 0; i < 20 && !found; i++) begin
            @(negedge clk);
            if (res_valid && res_thread == 2'(thr)) found = 1'b1;
        end
        check({req, " arrived"}, {31'd0, found}, 1);
        if (found) check({req, " data"}, {16'd0, res_data}, 32'(d));
    endtask

    task automatic pulse_step();
        step_end = 1'b1;
        @(negedge clk);
        step_end = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 res_valid", {31'd0, res_valid}, 0);
        check("R1 retry", {31'd0, retry}, 0);
        check("R1 addr_err", {31'd0, addr_err}, 0);
        check("R1 op_ready", {31'd0, op_ready}, 1);
    endtask

    task automatic t_accumulate();
        issue(1'b0, 0, 5, 1); expect_res("R2 first miss", 0, 0);
        issue(1'b0, 1, 5, 2); expect_res("R3 hit t1", 1, 1);
        issue(1'b0, 2, 5, 3); expect_res("R3 hit t2", 2, 3);
        issue(1'b0, 3, 5, 4); expect_res("R3 hit t3", 3, 6);
        pulse_step();
    endtask

    task automatic t_end_phase();
        issue(1'b1, 0, 5, 0);
        check("R7 no early result", {31'd0, res_valid}, 0);
        issue(1'b1, 1, 5, 1);
        check("R8 parked no result", {31'd0, res_valid}, 0);
        wait_res("R7 initiator old word", 0, 0);
        wait_res("R8 released", 1, 1);
        issue(1'b1, 2, 5, 3); expect_res("R6 immediate t2", 2, 3);
        issue(1'b1, 3, 5, 6); expect_res("R6 immediate t3", 3, 6);
    endtask

    task automatic t_commit();
        issue(1'b0, 2, 5, 7); expect_res("R5 miss after step", 2, 0);
        pulse_step();
        issue(1'b1, 2, 5, 0);
        wait_res("R7 stored sum", 2, 10);
        pulse_step();
    endtask

    task automatic t_conflict();
        issue(1'b0, 0, 1, 9); expect_res("R2 miss a1", 0, 0);
        issue(1'b0, 1, 3, 4);
        check("R4 retry", {31'd0, retry}, 1);
        check("R4 no result", {31'd0, res_valid}, 0);
        issue(1'b0, 2, 1, 1); expect_res("R4 line intact", 2, 9);
        issue(1'b0, 1, 2, 5); expect_res("R2 miss a2", 1, 0);
        pulse_step();
    endtask

    task automatic t_addr_error();
        issue(1'b1, 0, 0, 0);
        check("R9 addr_err", {31'd0, addr_err}, 1);
        check("R9 no result", {31'd0, res_valid}, 0);
    endtask

    task automatic t_busy();
        issue(1'b1, 0, 1, 0);
        issue(1'b1, 1, 2, 0);
        check("R10 retry while outstanding", {31'd0, retry}, 1);
        wait_res("R10 first reply", 0, 0);
        issue(1'b1, 2, 1, 9); expect_res("R6 after reply", 2, 9);
        issue(1'b1, 1, 2, 0);
        wait_res("R10 reissued reply", 1, 0);
        pulse_step();
        issue(1'b0, 3, 1, 0); expect_res("R2 miss a1 again", 3, 0);
        pulse_step();
        issue(1'b1, 3, 1, 0);
        wait_res("R7 total of a1", 3, 10);
        pulse_step();
        issue(1'b0, 0, 5, 0); pulse_step();
        issue(1'b1, 0, 5, 0);
        wait_res("R7 total of a5", 0, 17);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_accumulate();
        t_end_phase();
        t_commit();
        t_conflict();
        t_addr_error();
        t_busy();
        repeat (3) @(negedge clk);
        check("R11 idle outputs", {29'd0, res_valid, retry, addr_err}, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule